// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the instruction address of a small pipelined RISC core and decides, once per clock, where the next fetch comes from. On an ordinary step the address register counts up by one. When control flow changes, the register takes a parallel load instead. The loaded value comes from a single adder whose two operands are picked by multiplexers. For a taken branch-if-equal, the operands are the current address and the sign-extended branch offset. For an absolute jump, they are zero and the jump field.

The load strobe is the OR of two terms: the result of a full-width equality compare between two register operands, qualified by the branch-if-equal control bit, and the absolute-jump control bit. A stall input freezes the address. A synchronous reset returns it to zero. All address arithmetic wraps modulo 2^ADDR_W, which is 2^19 by default. Instruction decode, hazard detection and memory sit outside this block and only drive its control inputs.

Top module: `nia_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 at that edge, whatever `stall`, `is_beq` and `is_jump` hold.
- R2: With `stall`, `is_jump` and `is_beq` all low, `pc` advances to `pc + 1` at the next edge.
- R3: With `is_beq` high, `is_jump` low, `stall` low and `opnd_a == opnd_b`, `pc` becomes `pc + sext(br_ofs)` at the next edge, where `br_ofs` is a 16-bit two's-complement value.
- R4: With `is_beq` high but `opnd_a != opnd_b`, `br_ofs` has no effect and `pc` advances by one.
- R5: With `is_jump` high and `stall` low, `pc` becomes `jmp_field` at the next edge, whatever the operands and `br_ofs` hold.
- R6: When `is_jump` and `is_beq` are both high, the absolute target wins, even if the operands are equal.
- R7: With `stall` high and `rst` low, `pc` keeps its value, and stepping and loading are both suppressed.
- R8: Address arithmetic wraps modulo 2^19 in three cases: a step from 0x7FFFF gives 0, and an offset addition wraps past either end of the range.
- R9: The operand compare covers all 32 bits, so operands that differ only in bit 31 do not take the branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the address this cycle |
| is_beq | input | 1 | Current instruction is branch-if-equal |
| is_jump | input | 1 | Current instruction is an absolute jump |
| opnd_a | input | 32 | First register operand for the compare |
| opnd_b | input | 32 | Second register operand for the compare |
| br_ofs | input | 16 | Signed branch offset, relative to the current address |
| jmp_field | input | 19 | Absolute jump target |
| pc | output | 19 | Current instruction address |

## Verification
The address register drives `pc` directly, so any wrong next-state choice appears at the port in the cycle right after the edge that made it. Such an error can be a missed or spurious load, a step taken during a stall, or a wrong adder operand. Each scenario therefore samples `pc` one edge after applying its controls. A corrupted value then propagates through every later step, which makes it easy to see. Sign-extension and wrap faults only appear with offsets and addresses near the range ends, so those are driven on purpose.

// File: rtl/nia_pkg.sv
package nia_pkg;

    localparam int unsigned NIA_ADDR_W = 19;
    localparam int unsigned NIA_REG_W  = 32;
    localparam int unsigned NIA_OFS_W  = 16;

    // Next-state choice of the address register
    typedef enum logic [1:0] {
        NXT_HOLD = 2'd0,
        NXT_STEP = 2'd1,
        NXT_LOAD = 2'd2
    } nxt_e;

    // Control bundle carried from the ports into the unit
    typedef struct packed {
        logic stall;
        logic beq;
        logic jump;
    } nia_ctrl_t;

    // Stall dominates; otherwise a load beats a step
    function automatic nxt_e nxt_pick(input logic stall, input logic load);
        if (stall)
            return NXT_HOLD;
        else if (load)
            return NXT_LOAD;
        else
            return NXT_STEP;
    endfunction

endpackage

// File: rtl/nia_eq_cmp.sv
module nia_eq_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = a[i] ^ b[i];
    end

    assign eq = ~|diff;
endmodule

// File: rtl/nia_tgt_adder.sv
module nia_tgt_adder #(
    parameter int unsigned AW = 19,
    parameter int unsigned OW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [OW-1:0] ofs,
    input  logic [AW-1:0] abs_tgt,
    input  logic          sel_abs,
    output logic [AW-1:0] tgt
);
    logic [AW-1:0] ofs_ext;
    logic [AW-1:0] opnd_l;
    logic [AW-1:0] opnd_r;

    if (OW >= AW) begin : g_trunc
        assign ofs_ext = ofs[AW-1:0];
    end else begin : g_sext
        assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};
    end

    always_comb begin
        opnd_l = sel_abs ? '0      : cur;
        opnd_r = sel_abs ? abs_tgt : ofs_ext;
        tgt    = opnd_l + opnd_r;
    end
endmodule

// File: rtl/nia_counter.sv
module nia_counter
    import nia_pkg::*;
#(
    parameter int unsigned AW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  nxt_e          mode,
    input  logic [AW-1:0] ld_val,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (mode)
                NXT_STEP: q <= q + AW'(1);
                NXT_LOAD: q <= ld_val;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/nia_unit.sv
module nia_unit
    import nia_pkg::*;
#(
    parameter int unsigned ADDR_W = NIA_ADDR_W,
    parameter int unsigned REG_W  = NIA_REG_W,
    parameter int unsigned OFS_W  = NIA_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              is_beq,
    input  logic              is_jump,
    input  logic [REG_W-1:0]  opnd_a,
    input  logic [REG_W-1:0]  opnd_b,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [ADDR_W-1:0] jmp_field,
    output logic [ADDR_W-1:0] pc
);
    nia_ctrl_t     ctl;
    logic          opnd_eq;
    logic          load;
    nxt_e          mode;
    logic [ADDR_W-1:0] target;

    assign ctl = '{stall: stall, beq: is_beq, jump: is_jump};

    nia_eq_cmp #(.W(REG_W)) u_cmp (
        .a  (opnd_a),
        .b  (opnd_b),
        .eq (opnd_eq)
    );

    nia_tgt_adder #(.AW(ADDR_W), .OW(OFS_W)) u_add (
        .cur     (pc),
        .ofs     (br_ofs),
        .abs_tgt (jmp_field),
        .sel_abs (ctl.jump),
        .tgt     (target)
    );

    assign load = (ctl.beq & opnd_eq) | ctl.jump;
    assign mode = nxt_pick(ctl.stall, load);

    nia_counter #(.AW(ADDR_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .ld_val (target),
        .q      (pc)
    );
endmodule

// File: rtl/nia_unit_chk.sv
module nia_unit_chk #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned OFS_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              is_beq,
    input logic              is_jump,
    input logic [REG_W-1:0]  opnd_a,
    input logic [REG_W-1:0]  opnd_b,
    input logic [OFS_W-1:0]  br_ofs,
    input logic [ADDR_W-1:0] jmp_field,
    input logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] ofs_x;
    logic              hit;

    assign ofs_x = ADDR_W'($signed(br_ofs));
    assign hit   = is_beq && (opnd_a == opnd_b);

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (pc == '0));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !is_jump && !hit) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

    // R3
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !is_jump && hit) |=> (pc == ADDR_W'($past(pc) + $past(ofs_x))));

    // R5
    jump_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && is_jump) |=> (pc == $past(jmp_field)));
endmodule

bind nia_unit nia_unit_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .OFS_W  (OFS_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .is_beq    (is_beq),
    .is_jump   (is_jump),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .br_ofs    (br_ofs),
    .jmp_field (jmp_field),
    .pc        (pc)
);

// File: tb/nia_unit_tb_top.sv
module nia_unit_tb_top;
    localparam time CLK_P = 10ns;
    localparam int  AW    = 19;

    logic          clk = 1'b0;
    logic          rst;
    logic          stall;
    logic          is_beq;
    logic          is_jump;
    logic [31:0]   opnd_a;
    logic [31:0]   opnd_b;
    logic [15:0]   br_ofs;
    logic [AW-1:0] jmp_field;
    logic [AW-1:0] pc;

    logic [AW-1:0] exp_pc;
    int            n_chk = 0;
    int            n_err = 0;
    bit            done  = 0;

    always #(CLK_P/2) clk = ~clk;

    nia_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .is_beq    (is_beq),
        .is_jump   (is_jump),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .br_ofs    (br_ofs),
        .jmp_field (jmp_field),
        .pc        (pc)
    );

    task automatic check(input string req, input logic [AW-1:0] want);
        n_chk++;
        if (pc !== want) begin
            n_err++;
            $display("FAIL %s: pc=%h expected=%h", req, pc, want);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic r, input logic s, input logic b, input logic j,
                       input logic [31:0] a, input logic [31:0] bb,
                       input logic [15:0] o, input logic [AW-1:0] jf);
        rst = r; stall = s; is_beq = b; is_jump = j;
        opnd_a = a; opnd_b = bb; br_ofs = o; jmp_field = jf;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_step();
        cyc(0, 0, 0, 0, 32'h0, 32'h0, 16'h0, '0);
    endtask

    task automatic t_reset();
        cyc(1, 1, 1, 1, 32'h5, 32'h5, 16'h10, 19'h1234);
        exp_pc = '0;
        check("R1 reset with stall and jump", exp_pc);
    endtask

    task automatic t_step();
        for (int i = 0; i < 3; i++) begin
            idle_step();
            exp_pc = exp_pc + 1'b1;
            check("R2 sequential step", exp_pc);
        end
    endtask

    task automatic t_beq_taken();
        cyc(0, 0, 1, 0, 32'hCAFE_0001, 32'hCAFE_0001, 16'h0040, 19'h7_0000);
        exp_pc = exp_pc + 19'h40;
        check("R3 beq forward", exp_pc);
        cyc(0, 0, 1, 0, 32'h0, 32'h0, 16'hFFF0, 19'h0);
        exp_pc = exp_pc - 19'h10;
        check("R3 beq backward", exp_pc);
    endtask

    task automatic t_beq_not_taken();
        cyc(0, 0, 1, 0, 32'h1, 32'h2, 16'h0100, 19'h0);
        exp_pc = exp_pc + 1'b1;
        check("R4 beq unequal steps", exp_pc);
    endtask

    task automatic t_full_cmp();
        cyc(0, 0, 1, 0, 32'h8000_0007, 32'h0000_0007, 16'h0200, 19'h0);
        exp_pc = exp_pc + 1'b1;
        check("R9 bit31 difference not taken", exp_pc);
    endtask

    task automatic t_jump();
        cyc(0, 0, 0, 1, 32'h1, 32'h9, 16'h7777, 19'h2_3456);
        exp_pc = 19'h2_3456;
        check("R5 absolute jump", exp_pc);
    endtask

    task automatic t_both();
        cyc(0, 0, 1, 1, 32'h42, 32'h42, 16'h0008, 19'h0_0ABC);
        exp_pc = 19'h0_0ABC;
        check("R6 jump wins over beq", exp_pc);
    endtask

    task automatic t_stall();
        cyc(0, 1, 0, 0, 32'h0, 32'h0, 16'h0, '0);
        check("R7 stall holds step", exp_pc);
        cyc(0, 1, 0, 1, 32'h0, 32'h0, 16'h0, 19'h5_5555);
        check("R7 stall holds jump", exp_pc);
        cyc(0, 1, 1, 0, 32'h3, 32'h3, 16'h0020, '0);
        check("R7 stall holds beq", exp_pc);
    endtask

    task automatic t_wrap();
        cyc(0, 0, 0, 1, 32'h0, 32'h0, 16'h0, 19'h7_FFFF);
        exp_pc = 19'h7_FFFF;
        check("R5 jump to top", exp_pc);
        idle_step();
        exp_pc = '0;
        check("R8 step wraps to zero", exp_pc);
        cyc(0, 0, 0, 1, 32'h0, 32'h0, 16'h0, 19'h7_FFF0);
        exp_pc = 19'h7_FFF0;
        cyc(0, 0, 1, 0, 32'hA, 32'hA, 16'h0020, '0);
        exp_pc = 19'h0_0010;
        check("R8 add wraps past top", exp_pc);
        cyc(0, 0, 1, 0, 32'hB, 32'hB, 16'hFFEB, '0);
        exp_pc = 19'h7_FFFB;
        check("R8 add wraps below zero", exp_pc);
    endtask

    task automatic t_mid_reset();
        cyc(1, 0, 0, 0, 32'h0, 32'h0, 16'h0, '0);
        exp_pc = '0;
        check("R1 reset mid run", exp_pc);
        idle_step();
        exp_pc = 19'h1;
        check("R2 step after reset", exp_pc);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: pc=%h expected=run to finish", pc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        exp_pc = '0;
        @(negedge clk);
        t_reset();
        t_step();
        t_beq_taken();
        t_beq_not_taken();
        t_full_cmp();
        t_jump();
        t_both();
        t_stall();
        t_wrap();
        t_mid_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule